// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory with 128 bytes of storage. It watches a clock line and an open-drain data line, both sampled in the system clock domain. It finds start and stop conditions on the bus and decodes an address byte, which carries a 7-bit device identity and a direction bit. A write transfer then supplies a word pointer and up to a page of data. A read transfer returns bytes from the pointer onward.

Incoming write bytes go into a four-byte staging buffer that belongs to one page. When the master sends a stop, the buffer is copied into the array in a single cycle. A timed internal write period then begins. For its whole length the slave ignores the bus, so a master can poll for completion by sending an address byte and watching for the acknowledge.

Reads come in three forms: from the current pointer, from a pointer set by a write transfer that carries no data, and as a sequential stream. The master acknowledges each read byte on the ninth clock to keep the stream going. It withholds that acknowledge, or sends a stop, to end the transfer.

Top module: `eep_twowire_slave`

## Requirements
- R1: After reset, and whenever the slave is not addressed, `sda_oe` is 0, so the slave never pulls the data line low.
- R2: The first byte after a start is compared MSB first. Bits 7..1 must equal the parameter `DEV_ID`, and bit 0 selects the direction (1 = read, 0 = write). On a match the slave pulls the data line low on the ninth clock. On a mismatch it does not, and it ignores every bit until the next start.
- R3: In a write transfer, the byte after the address byte loads bits 6..0 into the word pointer and is acknowledged. Its bit 7 has no effect.
- R4: Each data byte after the pointer byte is acknowledged and staged for the pointer's location. Only pointer bits 1..0 then advance, and bits 6..2 stay fixed.
- R5: When more than four data bytes arrive before the stop, pointer bits 1..0 wrap to 0. The later bytes replace the earlier ones at the same locations.
- R6: A stop that follows at least one staged data byte writes the staged bytes to the array. It also starts a busy period of `WRITE_CYCLES` clocks. During that period no address byte is acknowledged and start and stop conditions are ignored. Once the period ends, the slave acknowledges again.
- R7: A write transfer that is ended by a repeated start, and not by a stop, changes no array byte and starts no busy period.
- R8: A read returns the byte at the pointer, MSB first. After each byte, all 7 bits of the pointer increment, and the pointer wraps from 127 to 0.
- R9: A read that begins directly with a read address byte continues from wherever the previous operation left the pointer.
- R10: A write transfer that carries only a pointer byte, followed by a repeated start and a read address byte, returns data from that pointer.
- R11: A low data line on the ninth clock of a read byte makes the slave send the next byte. A high data line on the ninth clock ends the read. A stop during the ninth clock also ends the read. After either ending, the slave releases the line and waits for a start.
- R12: `sda_oe` changes only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Resolved bus data line level |
| sda_oe | output | 1 | 1 = slave pulls the data line low |
| sda_out | output | 1 | Level driven when enabled; always 0 |

## Verification
If the decoder is in the wrong state, the effect appears at the very next ninth clock. An acknowledge is either missing or arrives where none should be, or the slave drives a data bit into a slot the master owns. A bad pointer or a bad staged byte shows up only in a later read. For that reason the bench fills every location and reads all of it back, including the wrap from the top of the array to the bottom, so a fault reaches the ports within one full array read. A busy period of the wrong length shows up as an acknowledge to a poll that lands inside or just after the window.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_ACK  = 3'd2,
        ST_TX   = 3'd3,
        ST_MACK = 3'd4,
        ST_BUSY = 3'd5
    } state_e;

    typedef enum logic [1:0] {
        RX_DEV   = 2'd0,
        RX_WADDR = 2'd1,
        RX_DATA  = 2'd2
    } rx_kind_e;

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    typedef struct packed {
        logic scl1;
        logic scl2;
        logic sda1;
        logic sda2;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.scl1 = scl_in;
        smp_d.scl2 = smp_q.scl1;
        smp_d.sda1 = sda_in;
        smp_d.sda2 = smp_q.sda1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_lvl   = smp_q.scl1;
    assign sda_lvl   = smp_q.sda1;
    assign scl_rise  = smp_q.scl1 & ~smp_q.scl2;
    assign scl_fall  = ~smp_q.scl1 & smp_q.scl2;
    assign start_evt = smp_q.scl1 & smp_q.scl2 & smp_q.sda2 & ~smp_q.sda1;
    assign stop_evt  = smp_q.scl1 & smp_q.scl2 & ~smp_q.sda2 & smp_q.sda1;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 7,
    parameter int PB = 2,
    parameter int DW = 8,
    localparam int NB    = 1 << PB,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [AW-PB-1:0] wr_page,
    input  logic [NB*DW-1:0] wr_data,
    input  logic [NB-1:0]    wr_mask
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (wr_en && wr_mask[i]) begin
                mem_q[{wr_page, PB'(i)}] <= wr_data[i*DW +: DW];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int CYCLES = 2000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)           cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R6

endmodule

// File: rtl/eep_twowire_slave.sv
module eep_twowire_slave
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ID       = 7'h50,
    parameter int         AW           = 7,
    parameter int         PB           = 2,
    parameter int         WRITE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    output logic sda_out
);

    localparam int NB  = 1 << PB;
    localparam int DW  = 8;
    localparam int PGW = AW - PB;

    typedef struct packed {
        state_e           st;
        rx_kind_e         kind;
        logic [3:0]       cnt;
        logic [DW-1:0]    sh;
        logic             oe;
        logic             rw;
        logic             acked;
        logic [AW-1:0]    ptr;
        logic [NB*DW-1:0] stage;
        logic [NB-1:0]    mask;
    } regs_t;

    regs_t d, q;

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [DW-1:0] rd_data;
    logic          wr_en, tmr_start, busy;

    eep_line_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    eep_array #(.AW(AW), .PB(PB), .DW(DW)) u_arr (
        .clk     (clk),
        .rd_addr (q.ptr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_page (q.ptr[AW-1:PB]),
        .wr_data (q.stage),
        .wr_mask (q.mask)
    );

    eep_busy_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (busy)
    );

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        tmr_start = 1'b0;
        if (q.st == ST_BUSY) begin
            d.oe = 1'b0;
            if (!busy) d.st = ST_IDLE;
        end else if (start_evt) begin
            d.st   = ST_RX;
            d.kind = RX_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.mask = '0;
        end else if (stop_evt) begin
            d.oe = 1'b0;
            d.st = ST_IDLE;
            if (q.mask != '0) begin
                wr_en     = 1'b1;
                tmr_start = 1'b1;
                d.mask    = '0;
                d.st      = ST_BUSY;
            end
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[DW-2:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        case (q.kind)
                            RX_DEV: begin
                                if (q.sh[7:1] == DEV_ID) begin
                                    d.rw = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = ST_ACK;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            RX_WADDR: begin
                                d.ptr = q.sh[AW-1:0];
                                d.oe  = 1'b1;
                                d.st  = ST_ACK;
                            end
                            default: begin
                                d.stage[q.ptr[PB-1:0]*DW +: DW] = q.sh;
                                d.mask[q.ptr[PB-1:0]]           = 1'b1;
                                d.ptr = {q.ptr[AW-1:PB], q.ptr[PB-1:0] + PB'(1)};
                                d.oe  = 1'b1;
                                d.st  = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.kind == RX_DEV && q.rw) begin
                            d.st = ST_TX;
                            d.sh = rd_data;
                            d.oe = ~rd_data[DW-1];
                        end else begin
                            d.oe   = 1'b0;
                            d.st   = ST_RX;
                            d.kind = (q.kind == RX_DEV) ? RX_WADDR : RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.cnt   = '0;
                            d.oe    = 1'b0;
                            d.ptr   = q.ptr + AW'(1);
                            d.acked = 1'b0;
                            d.st    = ST_MACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.oe  = ~q.sh[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) d.st    = ST_IDLE;
                        else         d.acked = 1'b1;
                    end else if (scl_fall && q.acked) begin
                        d.acked = 1'b0;
                        d.st    = ST_TX;
                        d.cnt   = '0;
                        d.sh    = rd_data;
                        d.oe    = ~rd_data[DW-1];
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign sda_out = 1'b0;

    state_e          st_q;
    rx_kind_e        kind_q;
    logic [PGW-1:0]  page_q;
    assign st_q   = q.st;
    assign kind_q = q.kind;
    assign page_q = q.ptr[AW-1:PB];

    AST_OE_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl)); // R12

    AST_BUSY_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY) |-> !sda_oe); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_oe); // R1

    AST_PAGE_FIXED_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_RX && $past(kind_q) == RX_DATA && st_q == ST_ACK)
        |-> (page_q == $past(page_q))); // R4

endmodule

// File: tb/sim_eep_twowire_slave.sv
module sim_eep_twowire_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int WCYC       = 400;
    localparam int DEV_W      = 8'hA0;
    localparam int DEV_R      = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_oe, sda_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_mem [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    eep_twowire_slave #(.DEV_ID(7'h50), .WRITE_CYCLES(WCYC)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl),
        .sda_in  (sda_line),
        .sda_oe  (sda_oe),
        .sda_out (sda_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(Q);
        scl = 1'b1;   wclk(Q);
        m_sda = 1'b0; wclk(Q);
        scl = 1'b0;   wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q);
        scl = 1'b1;   wclk(Q);
        m_sda = 1'b1; wclk(Q);
    endtask

    task automatic send_bit(input bit b);
        m_sda = b;  wclk(Q);
        scl = 1'b1; wclk(Q);
        scl = 1'b0; wclk(Q);
    endtask

    task automatic recv_bit(output bit b);
        m_sda = 1'b1; wclk(Q);
        scl = 1'b1;   wclk(Q/2);
        b = sda_line; wclk(Q/2);
        scl = 1'b0;   wclk(Q);
    endtask

    task automatic send_byte(input int v, output bit ack);
        bit nb;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nb);
        ack = !nb;
    endtask

    task automatic read_byte(input bit mack, output int v);
        bit b;
        v = 0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            v = (v << 1) | int'(b);
        end
        send_bit(!mack);
    endtask

    // dummy write of the pointer, then repeated start with a read address byte
    task automatic point_read(input int a, input string tag);
        bit ack;
        bus_start();
        send_byte(DEV_W, ack); chk({tag, " dev ack"}, int'(ack), 1);
        send_byte(a, ack);     chk({tag, " ptr ack"}, int'(ack), 1);
        bus_start();
        send_byte(DEV_R, ack); chk({tag, " read dev ack"}, int'(ack), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1..all watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        int v;
        for (int a = 0; a < 128; a++) exp_mem[a] = (a * 37 + 11) & 255;

        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        chk("R1 reset release", int'(sda_oe), 0);

        // R2: identity mismatch is not acknowledged and the next byte is ignored
        bus_start();
        send_byte(8'hA4, ack); chk("R2 mismatch no ack", int'(ack), 0);
        send_byte(8'h00, ack); chk("R2 ignored after mismatch", int'(ack), 0);
        bus_stop();
        wclk(4);

        // R3 R4: fill the array one page at a time, pointer MSB set and ignored
        for (int p = 0; p < 32; p++) begin
            bus_start();
            send_byte(DEV_W, ack);        chk("R2 write dev ack", int'(ack), 1);
            send_byte(8'h80 | (p*4), ack); chk("R3 ptr ack", int'(ack), 1);
            for (int k = 0; k < 4; k++) begin
                send_byte(exp_mem[p*4 + k], ack); chk("R4 data ack", int'(ack), 1);
            end
            bus_stop();
            if (p == 0) begin
                // R6: a poll inside the busy period is not acknowledged
                bus_start();
                send_byte(DEV_W, ack); chk("R6 busy poll no ack", int'(ack), 0);
                bus_stop();
                wclk(WCYC + 20);
                bus_start();
                send_byte(DEV_W, ack); chk("R6 ack after busy", int'(ack), 1);
                bus_stop();
                wclk(4);
            end else begin
                wclk(WCYC + 20);
            end
        end

        // R10 R8 R11: random read from 0, stream through the wrap 127 -> 0
        point_read(0, "R10");
        for (int a = 0; a < 129; a++) begin
            read_byte(a != 128, v);
            chk("R8 sequential byte", v, exp_mem[a % 128]);
        end
        bus_stop();
        wclk(4);
        chk("R11 released after nack", int'(sda_oe), 0);

        // R9: current address read continues at pointer 1
        bus_start();
        send_byte(DEV_R, ack); chk("R9 dev ack", int'(ack), 1);
        read_byte(1'b0, v);    chk("R9 current byte", v, exp_mem[1]);
        bus_stop();
        wclk(4);

        // R5: six bytes into page 5 starting at offset 2
        bus_start();
        send_byte(DEV_W, ack); chk("R5 dev ack", int'(ack), 1);
        send_byte(22, ack);    chk("R5 ptr ack", int'(ack), 1);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'hC0 + k, ack); chk("R5 data ack", int'(ack), 1);
        end
        bus_stop();
        wclk(WCYC + 20);
        exp_mem[20] = 8'hC2; exp_mem[21] = 8'hC3;
        exp_mem[22] = 8'hC4; exp_mem[23] = 8'hC5;
        point_read(19, "R5");
        for (int a = 19; a < 25; a++) begin
            read_byte(a != 24, v);
            chk("R5 page wrap content", v, exp_mem[a]);
        end
        bus_stop();
        wclk(4);

        // R7: write ended by a repeated start commits nothing, no busy period
        bus_start();
        send_byte(DEV_W, ack); chk("R7 dev ack", int'(ack), 1);
        send_byte(40, ack);    chk("R7 ptr ack", int'(ack), 1);
        send_byte(8'h5A, ack); chk("R7 data ack", int'(ack), 1);
        bus_start();
        send_byte(DEV_R, ack); chk("R7 read ack, not busy", int'(ack), 1);
        read_byte(1'b0, v);    chk("R7 pointer advanced", v, exp_mem[41]);
        bus_stop();
        wclk(4);
        point_read(40, "R7");
        read_byte(1'b0, v);    chk("R7 byte unchanged", v, exp_mem[40]);
        bus_stop();
        wclk(4);

        // R11: stop during the ninth clock ends the read; pointer is then 42
        bus_start();
        send_byte(DEV_R, ack); chk("R11 dev ack", int'(ack), 1);
        v = 0;
        for (int i = 0; i < 8; i++) begin
            bit b;
            recv_bit(b);
            v = (v << 1) | int'(b);
        end
        chk("R11 byte before stop", v, exp_mem[41]);
        m_sda = 1'b0; wclk(Q);
        scl = 1'b1;   wclk(Q);
        m_sda = 1'b1; wclk(Q);
        chk("R11 released after ninth-clock stop", int'(sda_oe), 0);
        bus_start();
        send_byte(DEV_R, ack); chk("R11 ack after stop", int'(ack), 1);
        read_byte(1'b0, v);    chk("R11 next byte", v, exp_mem[42]);
        bus_stop();
        wclk(4);
        chk("R1 idle at end", int'(sda_oe), 0);
        chk("R1 sda_out level", int'(sda_out), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule